// File: doc/BRIEF.md
# Tagged Receive Character Queue with Idle Timeout

This block sits between a serial deserializer and a register read port. Each received character enters a 64-entry first-in first-out queue together with two tags: one for a framing error and one for a break condition. A data-register read returns the oldest character and removes it. The returned 32-bit word carries the byte and its tags. When nothing is buffered, the word carries an empty tag instead.

Software sees the fill state through a level word. That word holds the receive count and, in the byte above it, a transmit count supplied by the neighbouring transmit queue. The block raises two service requests:
- a trigger request, while the fill count is at or above a threshold chosen by a 3-bit code;
- a timeout request, when characters are waiting and the queue has seen neither a push nor a pop for a coded number of character times.

One character time is ten received-bit ticks. A character that arrives while the queue is full is dropped and reported by a one-cycle overrun pulse.

Top module: `rx_tag_fifo`

## Requirements
- R1: The queue holds 64 entries. `level_o` bits 7:0 give the number of buffered characters (0 to 64). Bits 15:8 repeat `tx_level_i`. Bits 31:16 are zero.
- R2: When the queue is not empty, `rd_word_o` shows the oldest entry: the byte in bits 7:0, bit 8 = 0, bit 9 = its framing-error tag, bit 10 = its break tag, and all other bits zero. When the queue is empty, `rd_word_o` equals 32'h0000_0100.
- R3: Characters leave in arrival order. A `rd_pop_i` cycle on a non-empty queue removes the oldest entry, and the next word appears on the following cycle.
- R4: A `rd_pop_i` cycle on an empty queue changes nothing. The level stays 0, and the next pushed character is the next one read.
- R5: A push while the queue holds 64 entries and no pop occurs in the same cycle is dropped: the level and the contents are unchanged, and `ovr_o` is high for exactly the following cycle. A push and a pop in the same cycle on a full queue are both accepted.
- R6: `trig_code_i` values 0, 1, 2, 3, 4 and 5 select thresholds of 1, 4, 8, 16, 32 and 48 characters. Values 6 and 7 select 48. `trig_req_o` is high exactly while the fill count is at or above the selected threshold.
- R7: `tmo_code_i` = 0 keeps `tmo_req_o` low. Values 1, 2 and 3 select 40, 80 and 160 `bit_tick_i` ticks (4, 8 and 16 character times of 10 ticks each). `tmo_req_o` rises once the queue is non-empty and that many ticks have been counted since the last push or pop.
- R8: The idle tick count restarts at every accepted push or pop and stays at zero while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | A received character is presented this cycle |
| rx_data_i | input | 8 | Received byte |
| rx_ferr_i | input | 1 | Framing-error tag for the character |
| rx_brk_i | input | 1 | Break tag for the character |
| bit_tick_i | input | 1 | One received-bit period has elapsed |
| rd_pop_i | input | 1 | Data-register read strobe; removes the oldest entry |
| trig_code_i | input | 3 | Trigger threshold code |
| tmo_code_i | input | 2 | Idle timeout code |
| tx_level_i | input | 8 | Transmit fill count, reported in the level word |
| rd_word_o | output | 32 | Data-register read word |
| level_o | output | 32 | Level word |
| trig_req_o | output | 1 | Fill count at or above threshold |
| tmo_req_o | output | 1 | Idle timeout request |
| ovr_o | output | 1 | One-cycle pulse for a dropped character |

## Verification
On every cycle, the assertions check four things:
- the fill count never exceeds the depth and moves by at most one per cycle;
- a pop on an empty queue leaves the pointers and the count alone;
- every overrun pulse follows a refused push;
- the trigger and timeout requests never appear while the level or the read word say the queue is empty.

Only the bench scenarios can show the rest: arrival order and tag placement in the read word, the exact threshold for each trigger code, the exact tick on which each timeout window expires, that a pop restarts the window, and that a dropped character leaves the stored contents untouched.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rxq_entry_t;

  localparam int unsigned ENTRY_W = $bits(rxq_entry_t);

  // threshold in characters for a trigger code
  function automatic int unsigned trig_chars(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  // idle window in character times for a timeout code (0 = off)
  function automatic int unsigned tmo_chars(input logic [1:0] code);
    case (code)
      2'd1:    return 4;
      2'd2:    return 8;
      2'd3:    return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rxq_entry_t    entry_i,
  input  logic          pop_i,
  output rxq_entry_t    head_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o,
  output logic          push_acc_o,
  output logic          pop_acc_o,
  output logic          ovr_o
);

  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full;

  assign empty_o    = (count == '0);
  assign full       = (count == CW'(DEPTH));
  assign pop_acc_o  = pop_i && !empty_o;
  assign push_acc_o = push_i && (!full || pop_i);

  always_ff @(posedge clk_i) begin
    if (push_acc_o) mem[wr_ptr] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_o  <= 1'b0;
    end else begin
      if (push_acc_o) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_acc_o)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_acc_o, pop_acc_o})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      ovr_o <= push_i && full && !pop_i;
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count;

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count + 1'b1 == $past(count)));

  assert_empty_pop_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> ($stable(rd_ptr) && $stable(wr_ptr) && count == '0));

  assert_ovr_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> ($past(push_i) && !$past(pop_i) && $past(count) == CW'(DEPTH)));

endmodule

// File: rtl/rxq_trigger.sv
`timescale 1ns/1ps
module rxq_trigger
  import rxq_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic [CW-1:0] count_i,
  input  logic [2:0]    code_i,
  output logic          req_o
);

  logic [CW-1:0] thr;

  assign thr   = CW'(trig_chars(code_i));
  assign req_o = (count_i >= thr);

endmodule

// File: rtl/rxq_idle_timer.sv
`timescale 1ns/1ps
module rxq_idle_timer
  import rxq_pkg::*;
#(
  parameter int unsigned CHAR_TICKS = 10,
  parameter int unsigned MAX_CHARS  = 16,
  localparam int unsigned LIMIT = MAX_CHARS * CHAR_TICKS,
  localparam int unsigned TW    = $clog2(LIMIT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic       empty_i,
  input  logic [1:0] code_i,
  output logic       req_o
);

  logic [TW-1:0] cnt, win;

  assign win = TW'(tmo_chars(code_i) * CHAR_TICKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt <= '0;
    else if (restart_i || empty_i)             cnt <= '0;
    else if (tick_i && cnt != TW'(LIMIT))      cnt <= cnt + 1'b1;
  end

  assign req_o = (code_i != 2'd0) && !empty_i && (cnt >= win);

  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(restart_i) || $past(empty_i)) |-> (cnt == '0));

endmodule

// File: rtl/rx_tag_fifo.sv
`timescale 1ns/1ps
module rx_tag_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned CHAR_TICKS = 10,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_ferr_i,
  input  logic        rx_brk_i,
  input  logic        bit_tick_i,
  input  logic        rd_pop_i,
  input  logic [2:0]  trig_code_i,
  input  logic [1:0]  tmo_code_i,
  input  logic [7:0]  tx_level_i,
  output logic [31:0] rd_word_o,
  output logic [31:0] level_o,
  output logic        trig_req_o,
  output logic        tmo_req_o,
  output logic        ovr_o
);

  rxq_entry_t    in_ent, head;
  logic          empty, push_acc, pop_acc;
  logic [CW-1:0] count;

  assign in_ent = '{brk: rx_brk_i, ferr: rx_ferr_i, data: rx_data_i};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i     (rx_push_i),
    .entry_i    (in_ent),
    .pop_i      (rd_pop_i),
    .head_o     (head),
    .empty_o    (empty),
    .count_o    (count),
    .push_acc_o (push_acc),
    .pop_acc_o  (pop_acc),
    .ovr_o      (ovr_o)
  );

  rxq_trigger #(.CW(CW)) u_trig (
    .count_i (count),
    .code_i  (trig_code_i),
    .req_o   (trig_req_o)
  );

  rxq_idle_timer #(.CHAR_TICKS(CHAR_TICKS), .MAX_CHARS(16)) u_tmo (
    .clk_i, .rst_ni,
    .tick_i    (bit_tick_i),
    .restart_i (push_acc || pop_acc),
    .empty_i   (empty),
    .code_i    (tmo_code_i),
    .req_o     (tmo_req_o)
  );

  assign rd_word_o = empty ? 32'h0000_0100
                           : {21'd0, head.brk, head.ferr, 1'b0, head.data};
  assign level_o   = {16'd0, tx_level_i, 8'(count)};

  assert_trig_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_req_o |-> (level_o[7:0] != 8'd0));

  assert_tmo_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_req_o |-> !rd_word_o[8]);

endmodule

// File: tb/sim_rx_tag_fifo.sv
`timescale 1ns/1ps
module sim_rx_tag_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, ferr = 1'b0, brk = 1'b0, tick = 1'b0, pop = 1'b0;
  logic [7:0]  data = '0, txl = '0;
  logic [2:0]  tcode = '0;
  logic [1:0]  mcode = '0;
  logic [31:0] word, level;
  logic        trig, tmo, ovr;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  rx_tag_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_push_i(push), .rx_data_i(data),
    .rx_ferr_i(ferr), .rx_brk_i(brk), .bit_tick_i(tick), .rd_pop_i(pop),
    .trig_code_i(tcode), .tmo_code_i(mcode), .tx_level_i(txl),
    .rd_word_o(word), .level_o(level), .trig_req_o(trig),
    .tmo_req_o(tmo), .ovr_o(ovr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_ch(input logic [7:0] d, input logic fe, input logic bk);
    push = 1'b1; data = d; ferr = fe; brk = bk;
    @(negedge clk);
    push = 1'b0; ferr = 1'b0; brk = 1'b0;
  endtask

  task automatic pop_one();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic drain();
    while (!word[8]) pop_one();
  endtask

  function automatic int thr_of(input int c);
    case (c)
      0: return 1; 1: return 4; 2: return 8; 3: return 16; 4: return 32;
      default: return 48;
    endcase
  endfunction

  task automatic t_reset();
    check("R2 reset word empty", word, 32'h100);
    check("R1 reset level", level, 32'h0);
    check("R6 reset trig", {31'd0, trig}, 32'd0);
    check("R7 reset tmo", {31'd0, tmo}, 32'd0);
  endtask

  task automatic t_tags_order();
    push_ch(8'h41, 1'b0, 1'b0);
    push_ch(8'h9C, 1'b1, 1'b0);
    push_ch(8'h00, 1'b0, 1'b1);
    check("R1 level 3", level[7:0], 32'd3);
    check("R2 plain char", word, 32'h41);
    pop_one();
    check("R2 R3 ferr tag", word, 32'h29C);
    pop_one();
    check("R2 R3 break tag", word, 32'h400);
    pop_one();
    check("R2 empty after drain", word, 32'h100);
  endtask

  task automatic t_empty_pop();
    pop_one();
    pop_one();
    check("R4 level after empty pop", level[7:0], 32'd0);
    push_ch(8'h77, 1'b0, 1'b0);
    check("R4 next char read", word, 32'h77);
    check("R4 level one", level[7:0], 32'd1);
    drain();
  endtask

  task automatic t_full_overrun();
    bit bad = 0;
    for (int i = 0; i < 64; i++) push_ch(8'(i), 1'b0, 1'b0);
    check("R1 level full", level[7:0], 32'd64);
    push_ch(8'hAA, 1'b0, 1'b0);
    check("R5 ovr pulse", {31'd0, ovr}, 32'd1);
    check("R5 level unchanged", level[7:0], 32'd64);
    @(negedge clk);
    check("R5 ovr one cycle", {31'd0, ovr}, 32'd0);
    push = 1'b1; data = 8'h55; pop = 1'b1;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    check("R5 push+pop on full", level[7:0], 32'd64);
    check("R5 no ovr on push+pop", {31'd0, ovr}, 32'd0);
    for (int i = 1; i < 64; i++) begin
      if (word !== 32'(i)) bad = 1;
      pop_one();
    end
    check("R3 R5 order kept", {31'd0, bad}, 32'd0);
    check("R5 accepted char last", word, 32'h55);
    pop_one();
    check("R1 empty again", level[7:0], 32'd0);
  endtask

  task automatic t_trigger();
    for (int c = 0; c < 8; c++) begin
      int t = thr_of(c);
      tcode = 3'(c);
      for (int k = 0; k < t - 1; k++) push_ch(8'(k), 1'b0, 1'b0);
      check($sformatf("R6 below thr code %0d", c), {31'd0, trig}, 32'd0);
      push_ch(8'hEE, 1'b0, 1'b0);
      check($sformatf("R6 at thr code %0d", c), {31'd0, trig}, 32'd1);
      pop_one();
      check($sformatf("R6 drop below code %0d", c), {31'd0, trig}, 32'd0);
      drain();
    end
    tcode = '0;
  endtask

  task automatic t_timeout();
    mcode = 2'd1;
    push_ch(8'h10, 1'b0, 1'b0);
    ticks(39);
    check("R7 code1 before 40", {31'd0, tmo}, 32'd0);
    ticks(1);
    check("R7 code1 at 40", {31'd0, tmo}, 32'd1);
    push_ch(8'h11, 1'b0, 1'b0);
    check("R8 push restarts", {31'd0, tmo}, 32'd0);
    ticks(30);
    pop_one();
    ticks(39);
    check("R8 pop restarts", {31'd0, tmo}, 32'd0);
    ticks(1);
    check("R8 fires after pop window", {31'd0, tmo}, 32'd1);
    mcode = 2'd3;
    push_ch(8'h12, 1'b0, 1'b0);
    ticks(159);
    check("R7 code3 before 160", {31'd0, tmo}, 32'd0);
    ticks(1);
    check("R7 code3 at 160", {31'd0, tmo}, 32'd1);
    mcode = 2'd2;
    check("R7 code2 within 80", {31'd0, tmo}, 32'd1);
    mcode = 2'd0;
    ticks(20);
    check("R7 code0 disabled", {31'd0, tmo}, 32'd0);
    drain();
    mcode = 2'd1;
    ticks(60);
    push_ch(8'h13, 1'b0, 1'b0);
    check("R8 empty held zero", {31'd0, tmo}, 32'd0);
    ticks(39);
    check("R8 count from push", {31'd0, tmo}, 32'd0);
    drain();
    mcode = 2'd0;
  endtask

  task automatic t_level_tx();
    txl = 8'hA5;
    push_ch(8'h01, 1'b0, 1'b0);
    push_ch(8'h02, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 level word", level, 32'h0000_A502);
    txl = 8'h00;
    drain();
  endtask

  initial begin
    #1_200_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tags_order();
    t_empty_pop();
    t_full_overrun();
    t_trigger();
    t_timeout();
    t_level_tx();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule